// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a small 16-bit processor's execution unit and a single memory bus. It keeps a six-byte instruction queue filled ahead of execution, presents the oldest byte to the execution unit over a valid/ready handshake, and shares the bus between speculative code fetches and operand reads or writes requested by the execution unit. Operand traffic always wins the bus, and code is fetched only while at least two queue slots are free.

Code addresses are formed from a 16-bit code base and a 16-bit fetch pointer: the base is shifted left by four bits and added to the pointer, giving a 20-bit bus address. A fetch reads a word from an even pointer and a single byte from an odd one, so later fetches are word aligned. A flush pulse, raised on any control transfer, empties the queue, loads a new base and pointer, and drops the data of any code fetch still outstanding. When the queue has no room and no operand access is waiting, the block raises no request and flags the bus as idle.

Top module: `ifq_prefetch_top`

## Requirements
- R1: Queue bytes reach `q_byte` in first-in first-out order; after a flush to base S and pointer P, the i-th byte delivered is the memory byte at address ((S << 4) + ((P + i) mod 2^16)) mod 2^20. A byte is removed only at a clock edge where `q_valid` and `q_ready` are both high, and `q_valid` is low while the queue is empty.
- R2: The queue holds six bytes, and a code fetch is launched only when at least two slots are free. With no consumer, a flush to an even pointer leads to exactly three code fetches; a flush to an odd pointer also leads to three (1 + 2 + 2 bytes), after which removing one byte allows a fourth, while removing one byte from a full queue allows none.
- R3: A code fetch from an odd address sets `bus_word` to 0 and takes its byte from `bus_rdata[7:0]`; one from an even address sets `bus_word` to 1 and takes the even-address byte from `bus_rdata[7:0]` and the next byte from `bus_rdata[15:8]`.
- R4: When an operand request is pending at an arbitration decision, the next bus cycle is the operand access, with `bus_addr` = `op_addr`, `bus_we` = `op_we`, `bus_wdata` = `op_wdata` and `bus_word` = 1, even if the queue has room.
- R5: `op_ack` is high for exactly one cycle, the cycle after the edge where `bus_ack` ends the operand cycle; for a read, `op_rdata` then holds the word returned on `bus_rdata`.
- R6: When fewer than two slots are free and no operand request is pending, `bus_req` stays low and `bus_idle` is high.
- R7: `bus_addr`, `bus_we`, `bus_wdata` and `bus_word` are held stable from the rise of `bus_req` until the edge where `bus_ack` is sampled high, and `bus_req` is low in the following cycle.
- R8: A flush empties the queue at the edge where it is sampled, so `q_valid` is low in the next cycle; data of a code fetch in flight at the flush is discarded, and later bytes follow R1 from the new base and pointer.
- R9: While reset is high, `q_valid`, `bus_req`, `bus_idle` and `op_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Control transfer: empty queue, load new base and pointer |
| flush_seg | input | 16 | New code base loaded on flush |
| flush_ptr | input | 16 | New fetch pointer loaded on flush |
| q_byte | output | 8 | Oldest queued instruction byte |
| q_valid | output | 1 | Queue holds at least one byte |
| q_ready | input | 1 | Execution unit takes the byte at this edge |
| op_req | input | 1 | Operand access request, held until `op_ack` |
| op_we | input | 1 | Operand access is a write |
| op_addr | input | 20 | Operand address |
| op_wdata | input | 16 | Operand write data |
| op_ack | output | 1 | One-cycle operand completion pulse |
| op_rdata | output | 16 | Operand read data |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_word | output | 1 | 1: word access, 0: single byte in low lane |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus cycle completes at this edge |
| bus_rdata | input | 16 | Bus read data, valid with `bus_ack` |
| bus_idle | output | 1 | Arbitration found no work this cycle |

## Verification
A request is raised one edge after the arbitration decision that sees the need, fetched bytes become visible on `q_valid`/`q_byte` one edge after the acknowledging edge, `op_ack` rises one edge after the acknowledging edge, and a flush clears `q_valid` at the edge that samples it. The bench drives every input and the bus model on the falling edge and samples outputs there, so each check reads the value settled by the preceding rising edge. Stream checks pair each delivered byte with a handshake that will complete at the next edge, and fetch-count and idle checks wait well past the last possible bus cycle before reading the count.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PF   = 2'd1,
    SEQ_OP   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/ifq_byte_queue.sv
module ifq_byte_queue #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [1:0]            push_n,
  input  logic [2*BYTE_W-1:0]   push_data,
  input  logic                  pop,
  output logic [BYTE_W-1:0]     head,
  output logic                  head_valid,
  output logic [CNT_W-1:0]      count
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] slot [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx, wr_nxt;
  logic              pop_ok;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign wr_nxt     = step_idx(wr_idx);
  assign head_valid = (count != '0);
  assign head       = slot[rd_idx];
  assign pop_ok     = pop && head_valid && !clr;

  // Storage has no reset so it maps onto plain memory cells.
  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_n != 2'd0 && wr_idx == IDX_W'(i))
          slot[i] <= push_data[BYTE_W-1:0];
        else if (push_n == 2'd2 && wr_nxt == IDX_W'(i))
          slot[i] <= push_data[2*BYTE_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      case (push_n)
        2'd1:    wr_idx <= wr_nxt;
        2'd2:    wr_idx <= step_idx(wr_nxt);
        default: wr_idx <= wr_idx;
      endcase
      if (pop_ok)
        rd_idx <= step_idx(rd_idx);
      count <= count + CNT_W'(push_n) - CNT_W'(pop_ok);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count) + int'(push_n) <= DEPTH));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

endmodule

// File: rtl/ifq_fetch_ptr.sv
module ifq_fetch_ptr #(
  parameter int SEG_W  = 16,
  parameter int PTR_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [PTR_W-1:0]  load_ptr,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              odd
);

  logic [SEG_W-1:0] seg_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      ptr_q <= '0;
    end else if (load) begin
      seg_q <= load_seg;
      ptr_q <= load_ptr;
    end else begin
      ptr_q <= ptr_q + PTR_W'(step);
    end
  end

  assign fetch_addr = ADDR_W'({seg_q, {SHIFT{1'b0}}}) + ADDR_W'(ptr_q);
  assign odd        = ptr_q[0];

endmodule

// File: rtl/ifq_bus_seq.sv
module ifq_bus_seq
  import ifq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              op_req,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_ack,
  output logic [DATA_W-1:0] op_rdata,
  input  logic [CNT_W-1:0]  q_count,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_odd,
  output logic [1:0]        push_n,
  output logic [DATA_W-1:0] push_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_idle
);

  seq_state_t st;
  logic       discard;
  logic       launch_op, launch_pf, room, pf_done, keep;

  assign room      = (q_count <= CNT_W'(DEPTH - 2));
  assign launch_op = (st == SEQ_IDLE) && op_req && !op_ack;
  assign launch_pf = (st == SEQ_IDLE) && !launch_op && !flush && room;
  assign pf_done   = (st == SEQ_PF) && bus_ack;
  assign keep      = pf_done && !discard && !flush;
  assign push_n    = keep ? (bus_word ? 2'd2 : 2'd1) : 2'd0;
  assign push_data = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_word  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      op_ack    <= 1'b0;
      op_rdata  <= '0;
      discard   <= 1'b0;
      bus_idle  <= 1'b0;
    end else begin
      op_ack <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (launch_op) begin
            st        <= SEQ_OP;
            bus_req   <= 1'b1;
            bus_we    <= op_we;
            bus_word  <= 1'b1;
            bus_addr  <= op_addr;
            bus_wdata <= op_wdata;
            bus_idle  <= 1'b0;
          end else if (launch_pf) begin
            st        <= SEQ_PF;
            bus_req   <= 1'b1;
            bus_we    <= 1'b0;
            bus_word  <= !pf_odd;
            bus_addr  <= pf_addr;
            bus_wdata <= '0;
            bus_idle  <= 1'b0;
          end else begin
            bus_idle  <= 1'b1;
          end
        end
        SEQ_PF: begin
          if (bus_ack) begin
            st      <= SEQ_IDLE;
            bus_req <= 1'b0;
            discard <= 1'b0;
          end else if (flush) begin
            discard <= 1'b1;
          end
        end
        SEQ_OP: begin
          if (bus_ack) begin
            st      <= SEQ_IDLE;
            bus_req <= 1'b0;
            op_ack  <= 1'b1;
            if (!bus_we)
              op_rdata <= bus_rdata;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata) && $stable(bus_word)));

  // R4
  op_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_IDLE && op_req && !op_ack) |=> (bus_req && bus_addr == $past(op_addr)));

  // R2
  pf_room_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && st == SEQ_PF) |-> ($past(q_count) <= CNT_W'(DEPTH - 2)));

  // R3
  pf_align_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_PF && bus_word) |-> !bus_addr[0]);

  // R6
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> !bus_req);

endmodule

// File: rtl/ifq_prefetch_top.sv
module ifq_prefetch_top #(
  parameter int DEPTH  = 6,
  parameter int SEG_W  = 16,
  parameter int PTR_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SEG_W-1:0]  flush_seg,
  input  logic [PTR_W-1:0]  flush_ptr,
  output logic [DATA_W/2-1:0] q_byte,
  output logic              q_valid,
  input  logic              q_ready,
  input  logic              op_req,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_ack,
  output logic [DATA_W-1:0] op_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_idle
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  q_count;
  logic [ADDR_W-1:0] pf_addr;
  logic              pf_odd;
  logic [1:0]        push_n;
  logic [DATA_W-1:0] push_data;

  ifq_byte_queue #(
    .DEPTH (DEPTH),
    .BYTE_W(BYTE_W),
    .CNT_W (CNT_W)
  ) queue_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (flush),
    .push_n    (push_n),
    .push_data (push_data),
    .pop       (q_ready),
    .head      (q_byte),
    .head_valid(q_valid),
    .count     (q_count)
  );

  ifq_fetch_ptr #(
    .SEG_W (SEG_W),
    .PTR_W (PTR_W),
    .SHIFT (SHIFT),
    .ADDR_W(ADDR_W)
  ) ptr_i (
    .clk       (clk),
    .rst       (rst),
    .load      (flush),
    .load_seg  (flush_seg),
    .load_ptr  (flush_ptr),
    .step      (push_n),
    .fetch_addr(pf_addr),
    .odd       (pf_odd)
  );

  ifq_bus_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .op_req   (op_req),
    .op_we    (op_we),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .op_ack   (op_ack),
    .op_rdata (op_rdata),
    .q_count  (q_count),
    .pf_addr  (pf_addr),
    .pf_odd   (pf_odd),
    .push_n   (push_n),
    .push_data(push_data),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata),
    .bus_idle (bus_idle)
  );

endmodule

// File: tb/ifq_prefetch_top_tb_top.sv
module ifq_prefetch_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0;
  logic [15:0] flush_ptr = '0;
  logic [7:0]  q_byte;
  logic        q_valid;
  logic        q_ready = 1'b0;
  logic        op_req = 1'b0;
  logic        op_we = 1'b0;
  logic [19:0] op_addr = '0;
  logic [15:0] op_wdata = '0;
  logic        op_ack;
  logic [15:0] op_rdata;
  logic        bus_req, bus_we, bus_word, bus_idle;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  int tests = 0;
  int fails = 0;
  int lat = 0;
  int wait_cnt = 0;
  int pf_starts = 0;
  logic        prev_req = 1'b0;
  logic [19:0] last_wr_addr = '0;
  logic [15:0] last_wr_data = '0;

  always #4 clk = ~clk;

  ifq_prefetch_top dut_i (
    .clk(clk), .rst(rst), .flush(flush), .flush_seg(flush_seg), .flush_ptr(flush_ptr),
    .q_byte(q_byte), .q_valid(q_valid), .q_ready(q_ready),
    .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_ack(op_ack), .op_rdata(op_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_idle(bus_idle)
  );

  function automatic logic [7:0] mb(input logic [19:0] a);
    int v;
    v = int'(a);
    return 8'((v * 13) ^ (v >> 7) ^ 8'h5A);
  endfunction

  function automatic logic [19:0] code_addr(input int s, input int p, input int i);
    return 20'((s << 4) + ((p + i) & 16'hFFFF));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus model and fetch monitor, both on the falling edge.
  always @(negedge clk) begin
    if (!rst && bus_req && !prev_req && bus_addr < 20'hF0000) begin
      pf_starts++;
      chk(bus_word == !bus_addr[0], "R3", "fetch size vs address parity",
          int'(bus_word), int'(!bus_addr[0]));
    end
    prev_req = bus_req;
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        bus_ack = 1'b1;
        if (bus_we) begin
          last_wr_addr = bus_addr;
          last_wr_data = bus_wdata;
        end else if (bus_word) begin
          bus_rdata = {mb(bus_addr + 20'd1), mb(bus_addr)};
        end else begin
          bus_rdata = {8'h00, mb(bus_addr)};
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic do_flush(input int s, input int p);
    @(negedge clk);
    flush = 1'b1;
    flush_seg = 16'(s);
    flush_ptr = 16'(p);
    @(negedge clk);
    flush = 1'b0;
    pf_starts = 0;
    chk(q_valid == 1'b0, "R8", "queue empty after flush", int'(q_valid), 0);
  endtask

  task automatic collect(input int s, input int p, input int n, input int pat);
    int got = 0;
    int k = 0;
    while (got < n && k < 4000) begin
      @(negedge clk);
      q_ready = ((k + pat) % 3) != 0;
      k++;
      if (q_ready && q_valid) begin
        chk(q_byte == mb(code_addr(s, p, got)), "R1", "stream byte",
            int'(q_byte), int'(mb(code_addr(s, p, got))));
        got++;
      end
    end
    chk(got == n, "R1", "bytes delivered", got, n);
    @(negedge clk);
    q_ready = 1'b0;
  endtask

  task automatic op_run(input bit we, input logic [19:0] a, input logic [15:0] wd);
    int guard = 0;
    op_we = we;
    op_addr = a;
    op_wdata = wd;
    op_req = 1'b1;
    while (bus_req && guard < 100) begin @(negedge clk); guard++; end
    while (!bus_req && guard < 100) begin @(negedge clk); guard++; end
    chk(bus_addr == a && bus_we == we && bus_word, "R4", "operand cycle goes first",
        int'(bus_addr), int'(a));
    if (we)
      chk(bus_wdata == wd, "R4", "operand write data", int'(bus_wdata), int'(wd));
    while (!op_ack && guard < 200) begin @(negedge clk); guard++; end
    chk(op_ack && !bus_req, "R5", "op_ack after bus_ack", int'(op_ack), 1);
    if (we)
      chk(last_wr_addr == a && last_wr_data == wd, "R4", "write reached bus",
          int'(last_wr_data), int'(wd));
    else
      chk(op_rdata == {mb(a + 20'd1), mb(a)}, "R5", "operand read data",
          int'(op_rdata), int'({mb(a + 20'd1), mb(a)}));
    op_req = 1'b0;
    @(negedge clk);
    chk(op_ack == 1'b0, "R5", "op_ack one cycle", int'(op_ack), 0);
  endtask

  task automatic fill_check(input int s, input int p, input int exp_full, input int exp_after);
    q_ready = 1'b0;
    do_flush(s, p);
    repeat (60) @(negedge clk);
    chk(pf_starts == exp_full, "R2", "fetches until no room", pf_starts, exp_full);
    chk(bus_idle && !bus_req, "R6", "idle when queue lacks room", int'(bus_idle), 1);
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
    repeat (30) @(negedge clk);
    chk(pf_starts == exp_after, "R2", "fetches after one pop", pf_starts, exp_after);
    chk(q_valid == 1'b1, "R1", "queue still holds bytes", int'(q_valid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!q_valid, "R9", "q_valid in reset", int'(q_valid), 0);
    chk(!bus_req, "R9", "bus_req in reset", int'(bus_req), 0);
    chk(!bus_idle, "R9", "bus_idle in reset", int'(bus_idle), 0);
    chk(!op_ack, "R9", "op_ack in reset", int'(op_ack), 0);
    rst = 1'b0;

    // R1 / R3 sweep over latency, pointer alignment and pointer wrap
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int j = 0; j < 6; j++) begin
        int p;
        int s;
        p = (j < 4) ? j : 16'hFFFC + j;
        s = 16'h1234 + l * 16'h0101 + j;
        do_flush(s, p);
        collect(s, p, 20, l + j);
      end
    end

    // R2 / R6 capacity and room rule
    lat = 1;
    fill_check(16'h2000, 16'h0010, 3, 3);
    fill_check(16'h2000, 16'h0011, 3, 4);

    // R4 / R5 operand precedence over a pending prefetch
    lat = 2;
    q_ready = 1'b0;
    do_flush(16'h3000, 16'h0020);
    while (!bus_req) @(negedge clk);
    op_run(1'b0, 20'hF0010, 16'h0000);
    op_run(1'b1, 20'hF0022, 16'hBEEF);
    // R6 then R4: idle with a full queue, operand still served
    repeat (60) @(negedge clk);
    chk(bus_idle && !bus_req, "R6", "idle before operand", int'(bus_idle), 1);
    op_run(1'b0, 20'hF0104, 16'h0000);

    // R8 flush while a fetch is in flight
    lat = 4;
    do_flush(16'h1111, 16'h0005);
    while (!bus_req) @(negedge clk);
    @(negedge clk);
    do_flush(16'h4444, 16'h0007);
    collect(16'h4444, 16'h0007, 16, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule